// File: doc/BRIEF.md
# Conductance Neuron Update Pipeline

This block advances a bank of spiking neurons by one integration step per sweep. A start pulse sends the neuron indices 0 to N-1 through a five-stage pipeline, one index per cycle, so up to five neurons are in progress at once. The stages are: state fetch, synaptic filtering, membrane update, gain and spike decision, and write-back. Each neuron's membrane potential, excitatory and inhibitory filter states and refractory gain live in an on-chip table that is reset to rest and rewritten on every sweep.

During the fetch cycle the block presents the neuron index. An external input table answers in the same cycle with one summed excitatory value and one summed inhibitory value; a neuron with no event gets zero. Synaptic drive is a filtered conductance: each input is added to a leaky recursive filter, so charge enters gradually. The drive is weighted by the distance from the membrane potential to an upper or a lower reversal level. The whole membrane change is scaled by a refractory gain, which drops to zero after a spike and recovers toward one. One result per neuron leaves the block in index order, and a done pulse marks the last one.

All values are two's complement fixed point with W bits and F fractional bits (default 16 and 8, so 1.0 = 256). Defaults: VREST 0, EHI 5120, ELO -1280, THR 2560, filter shifts 2 (excitatory) and 3 (inhibitory), leak shift 3, conductance shifts 2 and 2, gain-recovery shift 2. `>>>` is an arithmetic shift that rounds toward minus infinity.

Top module: `cond_neuron_pipe`

## Requirements
- R1: After reset, every neuron holds v = VREST, both filters = 0 and gain g = 1.0 (256), and fetchValid, spikeValid and done are 0.
- R2: A start pulse while idle drives fetchValid high for N consecutive cycles, with fetchIdx counting 0, 1, ..., N-1. A start pulse that arrives before the done pulse of the running sweep is ignored.
- R3: excIn and inhIn are sampled in the cycle in which fetchValid is high. A neuron given zero on both inputs while at rest stays at v = VREST.
- R4: Filters update as sE' = sat(sE - (sE >>> KEXC) + excIn) and sI' = sat(sI - (sI >>> KINH) + inhIn).
- R5: The membrane candidate is v' = sat(v + ((g * dv) >>> F)), where dv = ((sE' * (EHI - v)) >>> (F + GEXC)) - ((sI' * (v - ELO)) >>> (F + GINH)) - ((v - VREST) >>> KMEM). The g here is the gain stored from the previous step.
- R6: spikeOut is 1 exactly when v' >= THR. On a spike the stored v becomes VREST and the stored g becomes 0.
- R7: Without a spike, the stored v is v' and g becomes g + ((256 - g) >>> KREF).
- R8: The result for a neuron appears on spikeValid, spikeIdx, spikeOut and vOut exactly five cycles after its fetch cycle, in index order. vOut is the stored membrane value.
- R9: done is high for one cycle, together with the result for neuron N-1.
- R10: Every stored quantity saturates to the signed W-bit range instead of wrapping.
- R11: The state written back in one sweep is the state read in the next sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Begins a sweep when idle |
| excIn | input | W | Summed excitatory input for fetchIdx, signed Q(W-F).F |
| inhIn | input | W | Summed inhibitory input for fetchIdx, signed Q(W-F).F |
| fetchValid | output | 1 | fetchIdx is being fetched this cycle |
| fetchIdx | output | IW | Neuron index being fetched |
| spikeValid | output | 1 | Result outputs are valid |
| spikeIdx | output | IW | Neuron index of the result |
| spikeOut | output | 1 | Spike flag of the result |
| vOut | output | W | Stored membrane potential after the step |
| done | output | 1 | Result of the last neuron of the sweep |

## Verification
The assertions assume that excIn and inhIn are valid in the cycle where fetchValid is high. They also assume that start is only a pulse and that sweeps never overlap in the table, because write-back of a neuron always completes before that neuron is fetched again. The stimulus gives inputs only in fetch cycles. It gives zero for neurons without an event and starts a new sweep only after done, apart from one deliberate start pulse in the middle of a sweep, which must be ignored. The bench model recomputes every neuron from the requirement formulas in 64-bit integers. Its inputs range from silence to full-scale values that drive the filters and the membrane into saturation.

// File: rtl/cnp_pkg.sv
package cnp_pkg;
  typedef struct packed {
    logic issue;
    logic last;
  } cnpStrobe_t;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_RUN   = 2'd1,
    CS_DRAIN = 2'd2
  } ctrlState_t;
endpackage

// File: rtl/cnp_ctrl.sv
module cnp_ctrl
  import cnp_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          done,
  output cnpStrobe_t    strb,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

  ctrlState_t    state;
  logic          issueR;
  logic          lastR;
  logic [IW-1:0] idxR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= CS_IDLE;
      issueR <= 1'b0;
      lastR  <= 1'b0;
      idxR   <= '0;
    end else begin
      case (state)
        CS_IDLE: if (start) begin
          issueR <= 1'b1;
          idxR   <= '0;
          lastR  <= (N == 1);
          state  <= CS_RUN;
        end
        CS_RUN: begin
          if (lastR) begin
            issueR <= 1'b0;
            lastR  <= 1'b0;
            state  <= CS_DRAIN;
          end else begin
            idxR  <= idxR + 1'b1;
            lastR <= (idxR + 1'b1 == LAST_IDX);
          end
        end
        CS_DRAIN: if (done) state <= CS_IDLE;
        default: state <= CS_IDLE;
      endcase
    end
  end

  assign strb = '{issue: issueR, last: lastR};
  assign idx  = idxR;

  AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    issueR && idxR != '0 |-> $past(issueR) && $past(idxR) == idxR - 1'b1); // R2
  AST_SWEEP_GAP: assert property (@(posedge clk) disable iff (!rstN)
    issueR && idxR == '0 |-> !$past(issueR)); // R2
endmodule

// File: rtl/cnp_datapath.sv
module cnp_datapath
  import cnp_pkg::*;
#(
  parameter int W     = 16,
  parameter int F     = 8,
  parameter int N     = 16,
  parameter int IW    = 4,
  parameter int VREST = 0,
  parameter int EHI   = 5120,
  parameter int ELO   = -1280,
  parameter int THR   = 2560,
  parameter int KEXC  = 2,
  parameter int KINH  = 3,
  parameter int KMEM  = 3,
  parameter int KREF  = 2,
  parameter int GEXC  = 2,
  parameter int GINH  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  cnpStrobe_t          strb,
  input  logic [IW-1:0]       idx,
  input  logic signed [W-1:0] excIn,
  input  logic signed [W-1:0] inhIn,
  output logic                spikeValid,
  output logic [IW-1:0]       spikeIdx,
  output logic                spikeOut,
  output logic signed [W-1:0] vOut,
  output logic                done
);
  localparam int DW = 3 * W;
  localparam longint MAXL = (longint'(1) << (W - 1)) - 1;
  localparam longint MINL = -MAXL - 1;
  localparam logic signed [W-1:0] VREST_W = W'(VREST);
  localparam logic signed [W-1:0] EHI_W   = W'(EHI);
  localparam logic signed [W-1:0] ELO_W   = W'(ELO);
  localparam logic signed [W-1:0] THR_W   = W'(THR);
  localparam logic signed [W-1:0] ONE_W   = W'(longint'(1) << F);

  function automatic logic signed [W-1:0] sat(input logic signed [DW-1:0] x);
    if (x > DW'(MAXL)) return W'(MAXL);
    if (x < DW'(MINL)) return W'(MINL);
    return W'(x);
  endfunction

  // neuron state table
  logic signed [W-1:0] vTab [N];
  logic signed [W-1:0] eTab [N];
  logic signed [W-1:0] iTab [N];
  logic signed [W-1:0] gTab [N];

  // stage registers
  logic                p1Valid, p1Last, p2Valid, p2Last, p3Valid, p3Last, p4Valid, p4Last;
  logic [IW-1:0]       p1Idx, p2Idx, p3Idx, p4Idx;
  logic signed [W-1:0] p1V, p1E, p1I, p1G, p1Ex, p1In;
  logic signed [W-1:0] p2V, p2E, p2I, p2G;
  logic signed [W-1:0] p3V, p3G;
  logic signed [W-1:0] p4V, p4G, p4E, p4I, p3E, p3I;
  logic                p4Spk;

  // stage 2 filter math
  logic signed [DW-1:0] eSum, iSum;
  always_comb begin
    eSum = DW'(p1E) - (DW'(p1E) >>> KEXC) + DW'(p1Ex);
    iSum = DW'(p1I) - (DW'(p1I) >>> KINH) + DW'(p1In);
  end

  // stage 3 membrane math
  logic signed [DW-1:0] excT, inhT, leak, dv, vSum;
  always_comb begin
    excT = (DW'(p2E) * (DW'(EHI_W) - DW'(p2V))) >>> (F + GEXC);
    inhT = (DW'(p2I) * (DW'(p2V) - DW'(ELO_W))) >>> (F + GINH);
    leak = (DW'(p2V) - DW'(VREST_W)) >>> KMEM;
    dv   = excT - inhT - leak;
    vSum = DW'(p2V) + ((DW'(p2G) * dv) >>> F);
  end

  // stage 4 gain and spike math
  logic                spkNow;
  logic signed [W-1:0] gRec;
  always_comb begin
    spkNow = (p3V >= THR_W);
    gRec   = p3G + ((ONE_W - p3G) >>> KREF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {p1Valid, p1Last, p2Valid, p2Last, p3Valid, p3Last, p4Valid, p4Last} <= '0;
      {p1Idx, p2Idx, p3Idx, p4Idx} <= '0;
      {p1V, p1E, p1I, p1G, p1Ex, p1In} <= '0;
      {p2V, p2E, p2I, p2G, p3V, p3G, p3E, p3I} <= '0;
      {p4V, p4G, p4E, p4I} <= '0;
      p4Spk      <= 1'b0;
      spikeValid <= 1'b0;
      spikeIdx   <= '0;
      spikeOut   <= 1'b0;
      vOut       <= '0;
      done       <= 1'b0;
      for (int k = 0; k < N; k++) begin
        vTab[k] <= VREST_W;
        eTab[k] <= '0;
        iTab[k] <= '0;
        gTab[k] <= ONE_W;
      end
    end else begin
      // S1 fetch
      p1Valid <= strb.issue;
      p1Last  <= strb.last;
      p1Idx   <= idx;
      p1V     <= vTab[idx];
      p1E     <= eTab[idx];
      p1I     <= iTab[idx];
      p1G     <= gTab[idx];
      p1Ex    <= strb.issue ? excIn : '0;
      p1In    <= strb.issue ? inhIn : '0;
      // S2 synaptic filters
      p2Valid <= p1Valid; p2Last <= p1Last; p2Idx <= p1Idx;
      p2V <= p1V; p2G <= p1G;
      p2E <= sat(eSum);
      p2I <= sat(iSum);
      // S3 membrane
      p3Valid <= p2Valid; p3Last <= p2Last; p3Idx <= p2Idx;
      p3V <= sat(vSum); p3G <= p2G; p3E <= p2E; p3I <= p2I;
      // S4 gain and spike
      p4Valid <= p3Valid; p4Last <= p3Last; p4Idx <= p3Idx;
      p4Spk <= spkNow;
      p4V   <= spkNow ? VREST_W : p3V;
      p4G   <= spkNow ? '0 : gRec;
      p4E   <= p3E; p4I <= p3I;
      // S5 write-back
      if (p4Valid) begin
        vTab[p4Idx] <= p4V;
        eTab[p4Idx] <= p4E;
        iTab[p4Idx] <= p4I;
        gTab[p4Idx] <= p4G;
      end
      spikeValid <= p4Valid;
      spikeIdx   <= p4Idx;
      spikeOut   <= p4Valid & p4Spk;
      vOut       <= p4V;
      done       <= p4Valid & p4Last;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    spikeValid |-> $past(strb.issue, 5)); // R8
  AST_OUT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    spikeValid && spikeIdx != '0 |-> $past(spikeValid) && $past(spikeIdx) == spikeIdx - 1'b1); // R8
  AST_SPIKE_REST: assert property (@(posedge clk) disable iff (!rstN)
    spikeValid && spikeOut |-> vOut == VREST_W); // R6
  AST_SUB_THRESHOLD: assert property (@(posedge clk) disable iff (!rstN)
    spikeValid && !spikeOut |-> vOut < THR_W); // R6
  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    p4Valid |-> p4G >= '0 && p4G <= ONE_W); // R7
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rstN)
    done |-> spikeValid && spikeIdx == IW'(N - 1)); // R9
endmodule

// File: rtl/cond_neuron_pipe.sv
module cond_neuron_pipe
  import cnp_pkg::*;
#(
  parameter int W     = 16,
  parameter int F     = 8,
  parameter int N     = 16,
  parameter int IW    = (N > 1) ? $clog2(N) : 1,
  parameter int VREST = 0,
  parameter int EHI   = 5120,
  parameter int ELO   = -1280,
  parameter int THR   = 2560,
  parameter int KEXC  = 2,
  parameter int KINH  = 3,
  parameter int KMEM  = 3,
  parameter int KREF  = 2,
  parameter int GEXC  = 2,
  parameter int GINH  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic signed [W-1:0] excIn,
  input  logic signed [W-1:0] inhIn,
  output logic                fetchValid,
  output logic [IW-1:0]       fetchIdx,
  output logic                spikeValid,
  output logic [IW-1:0]       spikeIdx,
  output logic                spikeOut,
  output logic signed [W-1:0] vOut,
  output logic                done
);
  cnpStrobe_t    strb;
  logic [IW-1:0] idx;

  cnp_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .strb(strb), .idx(idx)
  );

  cnp_datapath #(
    .W(W), .F(F), .N(N), .IW(IW), .VREST(VREST), .EHI(EHI), .ELO(ELO), .THR(THR),
    .KEXC(KEXC), .KINH(KINH), .KMEM(KMEM), .KREF(KREF), .GEXC(GEXC), .GINH(GINH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(idx), .excIn(excIn), .inhIn(inhIn),
    .spikeValid(spikeValid), .spikeIdx(spikeIdx), .spikeOut(spikeOut),
    .vOut(vOut), .done(done)
  );

  assign fetchValid = strb.issue;
  assign fetchIdx   = idx;
endmodule

// File: tb/sim_cond_neuron_pipe.sv
`timescale 1ns/1ps
module sim_cond_neuron_pipe;
  localparam int N = 16, W = 16, F = 8, IW = 4;
  localparam longint VREST = 0, EHI = 5120, ELO = -1280, THR = 2560;
  localparam int KEXC = 2, KINH = 3, KMEM = 3, KREF = 2, GEXC = 2, GINH = 2;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic signed [W-1:0] excIn = '0, inhIn = '0;
  logic fetchValid, spikeValid, spikeOut, done;
  logic [IW-1:0] fetchIdx, spikeIdx;
  logic signed [W-1:0] vOut;

  always #2.5 clk = ~clk;

  cond_neuron_pipe #(.W(W), .F(F), .N(N), .IW(IW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .excIn(excIn), .inhIn(inhIn),
    .fetchValid(fetchValid), .fetchIdx(fetchIdx), .spikeValid(spikeValid),
    .spikeIdx(spikeIdx), .spikeOut(spikeOut), .vOut(vOut), .done(done)
  );

  int checks = 0, failures = 0;
  longint mV[N], mE[N], mI[N], mG[N];
  longint exStim[N], ihStim[N];
  bit     sValid[1:5];
  longint sIdx[1:5], sSpk[1:5], sV[1:5];
  int     expFetch, fetchCount;
  bit     doneSeen;
  string  curTag = "R1";
  int unsigned seed = 32'd7;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint satL(input longint x);
    longint mx = (longint'(1) << (W - 1)) - 1;
    if (x > mx) return mx;
    if (x < -mx - 1) return -mx - 1;
    return x;
  endfunction

  task automatic tick();
    longint dv, vn, n;
    @(negedge clk);
    chk(spikeValid == sValid[5], "R8", longint'(spikeValid), longint'(sValid[5]));
    if (sValid[5] && spikeValid) begin
      chk(longint'(spikeIdx) == sIdx[5], "R8", longint'(spikeIdx), sIdx[5]);
      chk(longint'(spikeOut) == sSpk[5], "R6", longint'(spikeOut), sSpk[5]);
      chk(longint'(vOut) == sV[5], curTag, longint'(vOut), sV[5]);
    end
    chk(done == (sValid[5] && sIdx[5] == N - 1), "R9", longint'(done),
        longint'(sValid[5] && sIdx[5] == N - 1));
    if (done) doneSeen = 1'b1;
    for (int k = 5; k >= 2; k--) begin
      sValid[k] = sValid[k-1]; sIdx[k] = sIdx[k-1]; sSpk[k] = sSpk[k-1]; sV[k] = sV[k-1];
    end
    if (fetchValid) begin
      n = longint'(fetchIdx);
      chk(n == expFetch, "R2", n, expFetch);
      expFetch++;
      fetchCount++;
      excIn = W'(exStim[n]);
      inhIn = W'(ihStim[n]);
      // reference: R4 filters, R5 membrane, R6/R7 gain, R10 saturation
      mE[n] = satL(mE[n] - (mE[n] >>> KEXC) + exStim[n]);
      mI[n] = satL(mI[n] - (mI[n] >>> KINH) + ihStim[n]);
      dv = ((mE[n] * (EHI - mV[n])) >>> (F + GEXC)) - ((mI[n] * (mV[n] - ELO)) >>> (F + GINH))
           - ((mV[n] - VREST) >>> KMEM);
      vn = satL(mV[n] + ((mG[n] * dv) >>> F));
      sValid[1] = 1'b1; sIdx[1] = n;
      if (vn >= THR) begin
        mV[n] = VREST; mG[n] = 0; sSpk[1] = 1;
      end else begin
        mV[n] = vn; mG[n] = mG[n] + (((longint'(1) << F) - mG[n]) >>> KREF); sSpk[1] = 0;
      end
      sV[1] = mV[n];
    end else begin
      sValid[1] = 1'b0;
      excIn = '0;
      inhIn = '0;
    end
  endtask

  task automatic runSweep(input string tag, input bit poke);
    curTag = tag;
    expFetch = 0; fetchCount = 0; doneSeen = 1'b0;
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int c = 0; c < 4 * N + 20 && !doneSeen; c++) begin
      start = (poke && c == 5);
      tick();
    end
    start = 1'b0;
    tick();
    tick();
    chk(fetchCount == N, "R2", fetchCount, N);
    chk(doneSeen, "R9", longint'(doneSeen), 1);
  endtask

  function automatic longint rnd(input int lim);
    seed = seed * 32'd1103515245 + 32'd12345;
    return longint'((seed >> 16) % lim);
  endfunction

  initial begin
    for (int k = 0; k < N; k++) begin
      mV[k] = VREST; mE[k] = 0; mI[k] = 0; mG[k] = longint'(1) << F;
      exStim[k] = 0; ihStim[k] = 0;
    end
    for (int k = 1; k <= 5; k++) begin
      sValid[k] = 1'b0; sIdx[k] = 0; sSpk[k] = 0; sV[k] = 0;
    end
    repeat (4) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    chk(!fetchValid, "R1", longint'(fetchValid), 0);
    chk(!spikeValid, "R1", longint'(spikeValid), 0);
    chk(!done, "R1", longint'(done), 0);

    // R3: silent inputs keep neurons at rest
    runSweep("R3", 1'b0);
    // R4: light, mixed drive; a start pulse mid-sweep must be ignored (R2)
    for (int k = 0; k < N; k++) begin
      exStim[k] = (k % 2 == 0) ? k * 20 : 0;
      ihStim[k] = (k % 2 == 1) ? k * 30 : 0;
    end
    runSweep("R4", 1'b1);
    // R5: pseudo-random moderate drive
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < N; k++) begin
        exStim[k] = rnd(400);
        ihStim[k] = rnd(300);
      end
      runSweep("R5", 1'b0);
    end
    // R10: full-scale inputs saturate filters and membrane
    for (int k = 0; k < N; k++) begin
      exStim[k] = (k % 2 == 0) ? 32767 : 0;
      ihStim[k] = (k % 2 == 1) ? 32767 : 0;
    end
    runSweep("R10", 1'b0);
    runSweep("R10", 1'b0);
    // R7: drive after spikes is scaled by a recovering gain
    for (int k = 0; k < N; k++) begin exStim[k] = 60; ihStim[k] = 10; end
    runSweep("R7", 1'b0);
    runSweep("R7", 1'b0);
    // R11: no input; decay continues from the stored state
    for (int k = 0; k < N; k++) begin exStim[k] = 0; ihStim[k] = 0; end
    runSweep("R11", 1'b0);
    runSweep("R11", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule